// File: doc/BRIEF.md
# Max-Log Soft-Output Reliability Combiner

This block sits at the output side of a soft-input soft-output trellis decoder for an eight-state recursive systematic convolutional code. For each trellis step it takes the forward state metrics, the backward state metrics, four branch metrics, the received systematic value and the a priori value. From these it produces a signed log-likelihood ratio, a hard bit decision and a saturated extrinsic value. The extrinsic value goes back to the partner decoder as its a priori input on the next half-iteration.

For each of the two input-bit hypotheses the unit forms the eight path sums alpha + gamma + beta over the trellis transitions. It finds the largest sum with a balanced compare-select tree of three levels and subtracts the bit-0 winner from the bit-1 winner. No logarithmic correction term is added. A register follows the adder stage and each tree level, so the unit accepts one step per clock and returns each result a fixed four cycles later. The state metric memories, the interleaver and iteration control belong to the surrounding decoder.

Top module: `llr_unit`

## Requirements
- R1: The trellis state is s = {d1,d2,d3}, with d1 in bit 2. For input bit u the feedback bit is a = u^d2^d3, the parity bit is p = a^d1^d3 and the next state is {a,d1,d2}. The branch metric for label {u,p} is slice gamma_i[(2u+p)*W +: W]. Each alpha, beta and gamma slice j is bits [j*W +: W], read as two's complement. llr_o equals the maximum over s of alpha[s]+gamma[{1,p}]+beta[next] for u=1, minus the same maximum for u=0.
- R2: out_valid is high in exactly the cycle four clock edges after a step with in_valid high was sampled. It is low in every other cycle.
- R3: Steps presented on consecutive cycles each give their own result on consecutive cycles, in order and without loss.
- R4: With out_valid high, hard_o is 1 when llr_o is greater than zero and 0 otherwise. An LLR of exactly zero gives 0.
- R5: ext_o equals llr_o − sys_i − apr_i, where sys_i and apr_i are the values of the same step. The result is clamped to the signed EW-bit range (−128..127 by default) and never wraps.
- R6: While rst_n is low, out_valid is low, including immediately when reset hits a full pipeline.
- R7: Path sums and the LLR carry enough width that all-maximum and all-minimum metric inputs give the exact arithmetic result.
- R8: In a cycle with out_valid low, llr_o and ext_o keep the values of the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Step inputs are present this cycle |
| alpha_i | input | 8*W | Forward state metrics, state j in slice j |
| beta_i | input | 8*W | Backward state metrics, state j in slice j |
| gamma_i | input | 4*W | Branch metrics indexed by label {u,p} |
| sys_i | input | CW | Systematic channel value |
| apr_i | input | CW | A priori value |
| out_valid | output | 1 | Result present |
| llr_o | output | W+3 | Log-likelihood ratio |
| hard_o | output | 1 | Hard bit decision |
| ext_o | output | EW | Saturated extrinsic value |

## Verification
The hardest situation to reach is a step whose winning bit-1 path and losing bit-0 path sit at opposite ends of the metric range. Only then do the sum width and both ends of the extrinsic clamp get tested. Random metrics almost never produce it. Directed vectors push every alpha and beta to the positive limit and split gamma by hypothesis between its two extremes, once in each direction. A second hard case is a reset that arrives while all four pipeline stages hold live steps. The stimulus fills the pipeline with back-to-back steps and drops reset between edges, then checks that the output goes quiet at once.

// File: rtl/llr_pkg.sv
package llr_pkg;

  localparam int NSTATE = 8;
  localparam int NLABEL = 4;

  // feedback bit of the recursive encoder for state {d1,d2,d3} and input u
  function automatic logic trel_fb(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[0];
  endfunction

  function automatic logic trel_par(input logic [2:0] s, input logic u);
    return trel_fb(s, u) ^ s[2] ^ s[0];
  endfunction

  function automatic logic [2:0] trel_next(input logic [2:0] s, input logic u);
    return {trel_fb(s, u), s[2], s[1]};
  endfunction

endpackage

// File: rtl/llr_branch_sum.sv
module llr_branch_sum
  import llr_pkg::*;
#(
  parameter int W  = 10,
  parameter int XW = 16,
  localparam int SW = W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [NSTATE*W-1:0]  alpha_i,
  input  logic [NSTATE*W-1:0]  beta_i,
  input  logic [NLABEL*W-1:0]  gamma_i,
  input  logic [XW-1:0]        side_i,
  output logic                 v_o,
  output logic [NSTATE*SW-1:0] sum1_o,
  output logic [NSTATE*SW-1:0] sum0_o,
  output logic [XW-1:0]        side_o
);

  logic [NSTATE*SW-1:0] sum1_d, sum0_d;
  logic [NSTATE*SW-1:0] sum1_q, sum0_q;
  logic [XW-1:0]        side_q;
  logic                 v_q;

  // next-state: one path sum per (state, hypothesis)
  always_comb begin
    sum1_d = '0;
    sum0_d = '0;
    for (int s = 0; s < NSTATE; s++) begin
      for (int u = 0; u < 2; u++) begin
        logic [2:0]           ns;
        logic [1:0]           gl;
        logic signed [SW-1:0] a_x, b_x, g_x, t_x;
        ns  = trel_next(3'(s), 1'(u));
        gl  = {1'(u), trel_par(3'(s), 1'(u))};
        a_x = SW'($signed(alpha_i[s*W +: W]));
        b_x = SW'($signed(beta_i[ns*W +: W]));
        g_x = SW'($signed(gamma_i[gl*W +: W]));
        t_x = a_x + g_x + b_x;
        if (u == 1) sum1_d[s*SW +: SW] = t_x;
        else        sum0_d[s*SW +: SW] = t_x;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= en_i;
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      sum1_q <= sum1_d;
      sum0_q <= sum0_d;
      side_q <= side_i;
    end
  end

  assign v_o    = v_q;
  assign sum1_o = sum1_q;
  assign sum0_o = sum0_q;
  assign side_o = side_q;

endmodule

// File: rtl/llr_max_stage.sv
module llr_max_stage #(
  parameter int SW = 12,
  parameter int NI = 8,
  parameter int XW = 16,
  localparam int NO = NI / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [NI*SW-1:0] d1_i,
  input  logic [NI*SW-1:0] d0_i,
  input  logic [XW-1:0]    side_i,
  output logic             v_o,
  output logic [NO*SW-1:0] q1_o,
  output logic [NO*SW-1:0] q0_o,
  output logic [XW-1:0]    side_o
);

  logic [NO*SW-1:0] q1_d, q0_d, q1_q, q0_q;
  logic [XW-1:0]    side_q;
  logic             v_q;

  // one compare-select per pair, both hypotheses side by side
  for (genvar p = 0; p < NO; p++) begin : g_pair
    logic signed [SW-1:0] a1, b1, a0, b0;
    assign a1 = $signed(d1_i[(2*p)*SW +: SW]);
    assign b1 = $signed(d1_i[(2*p+1)*SW +: SW]);
    assign a0 = $signed(d0_i[(2*p)*SW +: SW]);
    assign b0 = $signed(d0_i[(2*p+1)*SW +: SW]);
    always_comb begin
      q1_d[p*SW +: SW] = (b1 > a1) ? b1 : a1;
      q0_d[p*SW +: SW] = (b0 > a0) ? b0 : a0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      q1_q   <= q1_d;
      q0_q   <= q0_d;
      side_q <= side_i;
    end
  end

  assign v_o    = v_q;
  assign q1_o   = q1_q;
  assign q0_o   = q0_q;
  assign side_o = side_q;

endmodule

// File: rtl/llr_ext_sat.sv
module llr_ext_sat #(
  parameter int LW = 13,
  parameter int CW = 8,
  parameter int EW = 8,
  localparam int RW = LW + 2
) (
  input  logic [LW-1:0] llr_i,
  input  logic [CW-1:0] sys_i,
  input  logic [CW-1:0] apr_i,
  output logic          hard_o,
  output logic [EW-1:0] ext_o
);

  localparam logic signed [RW-1:0] EHI = RW'((64'sd1 <<< (EW - 1)) - 64'sd1);
  localparam logic signed [RW-1:0] ELO = -EHI - RW'(1);

  logic signed [RW-1:0] raw;

  always_comb begin
    raw    = RW'($signed(llr_i)) - RW'($signed(sys_i)) - RW'($signed(apr_i));
    hard_o = ($signed(llr_i) > $signed(LW'(0)));
    if (raw > EHI)      ext_o = EHI[EW-1:0];
    else if (raw < ELO) ext_o = ELO[EW-1:0];
    else                ext_o = raw[EW-1:0];
  end

endmodule

// File: rtl/llr_unit.sv
module llr_unit
  import llr_pkg::*;
#(
  parameter int W  = 10,
  parameter int CW = 8,
  parameter int EW = 8,
  localparam int SW   = W + 2,
  localparam int LW   = W + 3,
  localparam int XW   = 2 * CW,
  localparam int NLVL = $clog2(NSTATE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NSTATE*W-1:0] alpha_i,
  input  logic [NSTATE*W-1:0] beta_i,
  input  logic [NLABEL*W-1:0] gamma_i,
  input  logic [CW-1:0]       sys_i,
  input  logic [CW-1:0]       apr_i,
  output logic                out_valid,
  output logic [LW-1:0]       llr_o,
  output logic                hard_o,
  output logic [EW-1:0]       ext_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // stage 1: path sums
  logic                 s1_v;
  logic [NSTATE*SW-1:0] s1_sum1, s1_sum0;
  logic [XW-1:0]        s1_side;

  llr_branch_sum #(.W(W), .XW(XW)) i_sum (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (in_valid),
    .alpha_i (alpha_i),
    .beta_i  (beta_i),
    .gamma_i (gamma_i),
    .side_i  ({sys_i, apr_i}),
    .v_o     (s1_v),
    .sum1_o  (s1_sum1),
    .sum0_o  (s1_sum0),
    .side_o  (s1_side)
  );

  // stages 2..4: registered compare-select levels
  for (genvar k = 0; k < NLVL; k++) begin : g_lvl
    localparam int NI = NSTATE >> k;
    localparam int NO = NI / 2;
    logic [NI*SW-1:0] d1, d0;
    logic [NO*SW-1:0] q1, q0;
    logic [XW-1:0]    si, so;
    logic             vi, vo;

    if (k == 0) begin : g_head
      assign d1 = s1_sum1;
      assign d0 = s1_sum0;
      assign si = s1_side;
      assign vi = s1_v;
    end else begin : g_link
      assign d1 = g_lvl[k-1].q1;
      assign d0 = g_lvl[k-1].q0;
      assign si = g_lvl[k-1].so;
      assign vi = g_lvl[k-1].vo;
    end

    llr_max_stage #(.SW(SW), .NI(NI), .XW(XW)) i_cs (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .v_i    (vi),
      .d1_i   (d1),
      .d0_i   (d0),
      .side_i (si),
      .v_o    (vo),
      .q1_o   (q1),
      .q0_o   (q0),
      .side_o (so)
    );
  end

  logic signed [SW-1:0] win1, win0;
  logic [XW-1:0]        fin_side;

  assign win1     = $signed(g_lvl[NLVL-1].q1);
  assign win0     = $signed(g_lvl[NLVL-1].q0);
  assign fin_side = g_lvl[NLVL-1].so;

  assign out_valid = g_lvl[NLVL-1].vo;
  assign llr_o     = LW'(win1) - LW'(win0);

  llr_ext_sat #(.LW(LW), .CW(CW), .EW(EW)) i_ext (
    .llr_i  (llr_o),
    .sys_i  (fin_side[XW-1 -: CW]),
    .apr_i  (fin_side[CW-1:0]),
    .hard_o (hard_o),
    .ext_o  (ext_o)
  );

endmodule

// File: rtl/llr_unit_chk.sv
module llr_unit_chk #(
  parameter int W  = 10,
  parameter int CW = 8,
  parameter int EW = 8,
  localparam int LW = W + 3,
  localparam int RW = LW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [CW-1:0] sys_i,
  input logic [CW-1:0] apr_i,
  input logic          out_valid,
  input logic [LW-1:0] llr_o,
  input logic          hard_o,
  input logic [EW-1:0] ext_o
);

  localparam logic signed [RW-1:0] CHI = RW'((64'sd1 <<< (EW - 1)) - 64'sd1);
  localparam logic signed [RW-1:0] CLO = -CHI - RW'(1);

  logic [2:0]    cnt;
  logic [CW-1:0] sys_dl [4];
  logic [CW-1:0] apr_dl [4];
  logic signed [RW-1:0] want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd7) cnt <= cnt + 3'd1;
  end

  always_ff @(posedge clk) begin
    sys_dl[0] <= sys_i;
    apr_dl[0] <= apr_i;
    for (int i = 1; i < 4; i++) begin
      sys_dl[i] <= sys_dl[i-1];
      apr_dl[i] <= apr_dl[i-1];
    end
  end

  assign want = RW'($signed(llr_o)) - RW'($signed(sys_dl[3])) - RW'($signed(apr_dl[3]));

  // R2
  lat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R4
  hard_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hard_o == ($signed(llr_o) > 0)));

  // R5
  ext_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && out_valid && want > CHI) |-> ($signed(ext_o) == CHI[EW-1:0]));

  // R5
  ext_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && out_valid && want < CLO) |-> (ext_o == CLO[EW-1:0]));

  // R5
  ext_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && out_valid && want <= CHI && want >= CLO) |-> (ext_o == want[EW-1:0]));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd1 && !out_valid) |-> ($stable(llr_o) && $stable(ext_o)));

  // R6
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

bind llr_unit llr_unit_chk #(.W(W), .CW(CW), .EW(EW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .in_valid  (in_valid),
  .sys_i     (sys_i),
  .apr_i     (apr_i),
  .out_valid (out_valid),
  .llr_o     (llr_o),
  .hard_o    (hard_o),
  .ext_o     (ext_o)
);

// File: tb/test_llr_unit.sv
module test_llr_unit;

  localparam int W  = 10;
  localparam int CW = 8;
  localparam int EW = 8;
  localparam int LW = W + 3;
  localparam int MAXW = (1 << (W - 1)) - 1;
  localparam int MINW = -(1 << (W - 1));

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [8*W-1:0]  alpha, beta;
  logic [4*W-1:0]  gamma;
  logic [CW-1:0]   sys, apr;
  logic            out_valid;
  logic [LW-1:0]   llr_o;
  logic            hard_o;
  logic [EW-1:0]   ext_o;

  always #2.5 clk = ~clk;

  llr_unit #(.W(W), .CW(CW), .EW(EW)) i_llr_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .alpha_i   (alpha),
    .beta_i    (beta),
    .gamma_i   (gamma),
    .sys_i     (sys),
    .apr_i     (apr),
    .out_valid (out_valid),
    .llr_o     (llr_o),
    .hard_o    (hard_o),
    .ext_o     (ext_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int ta [8];
  int tb [8];
  int tg [4];
  int ts, tp;

  logic [3:0] hist;
  int   q_llr [$];
  int   q_ext [$];
  bit   have_last;
  int   last_llr, last_ext;

  // encoder model from the stated recurrence
  function automatic int fb(input int s, input int u);
    return (u ^ ((s >> 1) & 1) ^ (s & 1));
  endfunction
  function automatic int par(input int s, input int u);
    return fb(s, u) ^ ((s >> 2) & 1) ^ (s & 1);
  endfunction
  function automatic int nxt(input int s, input int u);
    return (fb(s, u) << 2) | (((s >> 2) & 1) << 1) | ((s >> 1) & 1);
  endfunction

  function automatic int model_llr();
    int m [2];
    for (int u = 0; u < 2; u++) begin
      m[u] = -100000;
      for (int s = 0; s < 8; s++) begin
        int t;
        t = ta[s] + tg[2*u + par(s, u)] + tb[nxt(s, u)];
        if (t > m[u]) m[u] = t;
      end
    end
    return m[1] - m[0];
  endfunction

  function automatic int clampe(input int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out();
    bit ev;
    ev = hist[3];
    // R2 and R3: valid timing
    chk(out_valid == ev, "R2/R3 out_valid", int'(out_valid), int'(ev));
    if (ev && q_llr.size() > 0) begin
      int el, ee;
      el = q_llr.pop_front();
      ee = q_ext.pop_front();
      chk($signed(llr_o) == el, "R1/R7 llr", int'($signed(llr_o)), el);
      chk(hard_o == (el > 0), "R4 hard", int'(hard_o), int'(el > 0));
      chk($signed(ext_o) == ee, "R5 ext", int'($signed(ext_o)), ee);
      have_last = 1; last_llr = el; last_ext = ee;
    end else if (!ev && have_last) begin
      // R8: held while idle
      chk($signed(llr_o) == last_llr, "R8 llr hold", int'($signed(llr_o)), last_llr);
      chk($signed(ext_o) == last_ext, "R8 ext hold", int'($signed(ext_o)), last_ext);
    end
  endtask

  task automatic drive(input bit v);
    for (int s = 0; s < 8; s++) begin
      alpha[s*W +: W] = W'(ta[s]);
      beta[s*W +: W]  = W'(tb[s]);
    end
    for (int j = 0; j < 4; j++) gamma[j*W +: W] = W'(tg[j]);
    sys = CW'(ts);
    apr = CW'(tp);
    in_valid = v;
    if (v) begin
      int l;
      l = model_llr();
      q_llr.push_back(l);
      q_ext.push_back(clampe(l - ts - tp));
    end
    hist = {hist[2:0], v};
  endtask

  task automatic step(input bit v);
    @(negedge clk);
    check_out();
    drive(v);
  endtask

  function automatic int rnd_w();
    return int'($urandom % (1 << W)) + MINW;
  endfunction
  function automatic int rnd_c();
    return int'($urandom % 256) - 128;
  endfunction

  task automatic set_all(input int a, input int b, input int g);
    for (int s = 0; s < 8; s++) begin ta[s] = a; tb[s] = b; end
    for (int j = 0; j < 4; j++) tg[j] = g;
  endtask

  task automatic set_rand();
    for (int s = 0; s < 8; s++) begin ta[s] = rnd_w(); tb[s] = rnd_w(); end
    for (int j = 0; j < 4; j++) tg[j] = rnd_w();
    ts = rnd_c();
    tp = rnd_c();
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) step(1'b0);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; alpha = '0; beta = '0; gamma = '0; sys = '0; apr = '0;
    hist = '0; have_last = 0; last_llr = 0; last_ext = 0;
    set_all(0, 0, 0); ts = 0; tp = 0;
    // R6: quiet under reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);

    // directed corners
    set_all(0, 0, 0); ts = 0; tp = 0; step(1'b1);
    set_all(5, 5, 5); ts = 3; tp = -4; step(1'b1);                 // R4 tie, LLR 0
    set_all(MAXW, MAXW, MAXW); ts = 0; tp = 0; step(1'b1);         // R7
    set_all(MINW, MINW, MINW); ts = 0; tp = 0; step(1'b1);         // R7
    set_all(MAXW, MAXW, 0);                                        // R5 high clamp
    tg[0] = MINW; tg[1] = MINW; tg[2] = MAXW; tg[3] = MAXW; ts = -128; tp = -128; step(1'b1);
    tg[0] = MAXW; tg[1] = MAXW; tg[2] = MINW; tg[3] = MINW; ts = 127; tp = 127; step(1'b1);  // R5 low clamp
    set_all(0, 0, 0); ta[3] = 200; tg[2] = 7; ts = 10; tp = 20; step(1'b1);  // R1 one path
    set_all(1, 1, 1); tg[0] = 4; tg[1] = 3; ts = 1; tp = 1; step(1'b1);      // R4 negative
    flush();

    // R3: back-to-back random stream, then sparse stream with gaps (R8)
    for (int i = 0; i < 1500; i++) begin set_rand(); step(1'b1); end
    for (int i = 0; i < 1500; i++) begin set_rand(); step(($urandom % 4) == 0); end
    flush();

    // R6: reset with a full pipeline
    for (int i = 0; i < 4; i++) begin set_rand(); step(1'b1); end
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(out_valid == 1'b0, "R6 reset mid-stream", int'(out_valid), 0);
    in_valid = 1'b0;
    q_llr.delete(); q_ext.delete(); hist = '0; have_last = 0;
    for (int i = 0; i < 2; i++) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    for (int i = 0; i < 20; i++) begin set_rand(); step(1'b1); end
    flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule